// File: doc/BRIEF.md
# Fractional Clock Divider Configuration Encoder

This block turns a requested clock divide ratio into the three 16-bit configuration words that program one counter (an output counter or the feedback counter) of a clock synthesizer. The ratio is given as a 7-bit integer part and a 3-bit fraction in eighths. The encoder splits the ratio into high-phase and low-phase counts and an odd-ratio edge bit. In fractional mode it also applies the corrections for the rise-waveform bit, the fall-waveform bit and the fractional phase.

The block also holds the inverse decoder, which takes the first two configuration words and returns the programmed ratio in eighths. Software or a configuration sequencer uses the decoder to recover the active setting.

Each direction is a one-stage valid/ready stream. A beat is accepted on a rising clock edge where both valid and ready are high. The result shows up with its valid flag on the next edge. While a result is valid but not accepted, it is held unchanged and the input ready stays low, so back-pressure travels upstream in the same cycle. Input ready is high whenever the stage is empty or its output is being taken.

Top module: `fdiv_cfg_codec`

## Requirements
- R1: An integer part of 1 gives word2 = 0x0040 (only the bypass flag, bit 6), and word1 = word3 = 0. The fraction is ignored.
- R2: With fraction 0 and an integer part d ≥ 2, high = d/2 (rounded down), low = d − high, and edge = d mod 2. Word1 holds low in bits 5:0 and high in bits 11:6. Edge is bit 7 of word2. Word3 is 0.
- R3: With fraction f ≠ 0 and d ≥ 2, the following fields are set:
  - word2 bit 11 is set and word2 bits 14:12 hold f.
  - high = d/2, reduced by 1 when edge = 0.
  - low = d/2, reduced by 1 when edge = 0 or f = 1.
  - The rise-waveform bit (word2 bit 10) equals NOT edge.
- R4: In fractional mode, word3 is filled as follows:
  - Bit 10 (fall-waveform) is set when (edge = 0) XOR (f = 1), or when d = 2 and f = 1.
  - Bits 13:11 hold edge·4 + f/2.
- R5: The decoder returns 8 whenever word2 bit 6 is set, whatever the other bits are.
- R6: Otherwise the decoder returns (word1[5:0] + word1[11:6])·8. If word2 bit 11 is set, it then adds a correction and the fraction:
  - It adds 8 when bit 7 is set and bits 14:12 ≠ 1.
  - Otherwise it adds 16.
  - In both cases it then adds bits 14:12.
- R7: An integer part of 0, or a ratio whose counts do not fit in 6 bits (integer 127 with fraction 0), raises the error flag. All three words are then 0.
- R8: For every legal pair with d ≥ 2, decoding the encoder's words returns d·8 + f.
- R9: A valid output that is not accepted stays valid with unchanged data. In the same cycle its input ready is low.
- R10: A beat accepted at one edge is valid at the output after that edge.
- R11: After reset both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Ratio beat valid |
| enc_in_ready | output | 1 | Encoder can accept a ratio |
| enc_in_int | input | 7 | Integer part of the ratio |
| enc_in_frac | input | 3 | Fraction in eighths |
| enc_out_valid | output | 1 | Configuration words valid |
| enc_out_ready | input | 1 | Downstream takes the words |
| enc_out_word1 | output | 16 | Count word (high/low) |
| enc_out_word2 | output | 16 | Mode word (bypass, edge, fraction) |
| enc_out_word3 | output | 16 | Phase word (fall waveform, phase) |
| enc_out_err | output | 1 | Ratio could not be encoded |
| dec_in_valid | input | 1 | Word pair valid |
| dec_in_ready | output | 1 | Decoder can accept a pair |
| dec_in_word1 | input | 16 | Count word to decode |
| dec_in_word2 | input | 16 | Mode word to decode |
| dec_out_valid | output | 1 | Decoded ratio valid |
| dec_out_ready | input | 1 | Downstream takes the ratio |
| dec_out_eighths | output | 11 | Decoded ratio in eighths |

## Verification
The bench builds the block with its default 7-bit integer width. At that width the full input space of 1024 integer/fraction pairs is small enough to sweep completely. This reaches every branch of the fractional correction rules, the zero-integer error, and the single overflowing ratio at the top of the range. The round trip through the decoder is checked against d·8 + f for each pair. Hand-worked word values pin down the individual bit positions, and held back-pressure exercises the stall path of both streams.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int CNT_W   = 6;
  localparam int FRAC_W  = 3;
  localparam int WORD_W  = 16;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  // bit positions fixed by the counter hardware that reads these words
  localparam int W1_HIGH_LSB = 6;
  localparam int W2_BYPASS   = 6;
  localparam int W2_EDGE     = 7;
  localparam int W2_WFR      = 10;
  localparam int W2_FRAC_EN  = 11;
  localparam int W2_FRAC_LSB = 12;
  localparam int W3_WFF      = 10;
  localparam int W3_PH_LSB   = 11;

  typedef struct packed {
    logic [CNT_W-1:0]  high;
    logic [CNT_W-1:0]  low;
    logic              edge_b;
    logic              bypass;
    logic              frac_en;
    logic [FRAC_W-1:0] frac;
    logic              wf_rise;
    logic              wf_fall;
    logic [FRAC_W-1:0] phase;
  } cnt_fields_t;
endpackage

// File: rtl/fdiv_field_calc.sv
module fdiv_field_calc
  import fdiv_pkg::*;
#(
  parameter int INT_W = 7
) (
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output cnt_fields_t       fields,
  output logic              err
);
  logic [INT_W-1:0] half;
  logic [INT_W-1:0] lo_int;
  logic [INT_W-1:0] hi_frac;
  logic [INT_W-1:0] lo_frac;
  logic             odd;
  logic             frac_one;

  assign half     = div_int >> 1;
  assign odd      = div_int[0];
  assign frac_one = (div_frac == FRAC_W'(1));
  assign lo_int   = div_int - half;
  assign hi_frac  = half - INT_W'(!odd);
  assign lo_frac  = half - INT_W'(!odd || frac_one);

  always_comb begin
    fields = '0;
    err    = 1'b0;
    if (div_int == '0) begin
      err = 1'b1;
    end else if (div_int == INT_W'(1)) begin
      fields.bypass = 1'b1;
    end else if (div_frac == '0) begin
      if (int'(lo_int) > CNT_MAX || int'(half) > CNT_MAX) begin
        err = 1'b1;
      end else begin
        fields.high   = CNT_W'(half);
        fields.low    = CNT_W'(lo_int);
        fields.edge_b = odd;
      end
    end else begin
      if (int'(half) > CNT_MAX) begin
        err = 1'b1;
      end else begin
        fields.frac_en = 1'b1;
        fields.frac    = div_frac;
        fields.edge_b  = odd;
        fields.high    = CNT_W'(hi_frac);
        fields.low     = CNT_W'(lo_frac);
        fields.wf_rise = !odd;
        fields.wf_fall = ((!odd) ^ frac_one) ||
                         (div_int == INT_W'(2) && frac_one);
        fields.phase   = {odd, 2'b00} + (div_frac >> 1);
      end
    end
  end
endmodule

// File: rtl/fdiv_decoder.sv
module fdiv_decoder
  import fdiv_pkg::*;
#(
  parameter int EW = CNT_W + FRAC_W + 2
) (
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output logic [EW-1:0]     eighths
);
  logic [CNT_W:0]    cnt_sum;
  logic [FRAC_W-1:0] fr;
  logic [EW-1:0]     base;
  logic [EW-1:0]     corr;
  logic              unused_bits;

  assign cnt_sum = {1'b0, word1[CNT_W-1:0]} + {1'b0, word1[W1_HIGH_LSB +: CNT_W]};
  assign fr      = word2[W2_FRAC_LSB +: FRAC_W];
  assign base    = EW'({cnt_sum, {FRAC_W{1'b0}}});
  assign corr    = (word2[W2_EDGE] && fr != FRAC_W'(1)) ? EW'(8) : EW'(16);
  assign unused_bits = ^{word1[WORD_W-1:W1_HIGH_LSB+CNT_W], word2[WORD_W-1],
                         word2[W2_WFR], word2[W2_EDGE-1+3:W2_EDGE+1],
                         word2[W2_BYPASS-1:0]};

  always_comb begin
    if (word2[W2_BYPASS])
      eighths = EW'(8);
    else if (word2[W2_FRAC_EN])
      eighths = base + corr + EW'(fr);
    else
      eighths = base;
  end
endmodule

// File: rtl/fdiv_pipe_stage.sv
module fdiv_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/fdiv_cfg_codec.sv
module fdiv_cfg_codec
  import fdiv_pkg::*;
#(
  parameter int INT_W = 7,
  localparam int EW   = CNT_W + FRAC_W + 2,
  localparam int ENC_W = 3 * WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [INT_W-1:0]  enc_in_int,
  input  logic [FRAC_W-1:0] enc_in_frac,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [WORD_W-1:0] enc_out_word1,
  output logic [WORD_W-1:0] enc_out_word2,
  output logic [WORD_W-1:0] enc_out_word3,
  output logic              enc_out_err,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [WORD_W-1:0] dec_in_word1,
  input  logic [WORD_W-1:0] dec_in_word2,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [EW-1:0]     dec_out_eighths
);
  cnt_fields_t      f;
  logic             calc_err;
  logic [WORD_W-1:0] w1, w2, w3;
  logic [ENC_W-1:0] enc_q;
  logic [EW-1:0]    dec_val;

  fdiv_field_calc #(.INT_W(INT_W)) u_calc (
    .div_int (enc_in_int),
    .div_frac(enc_in_frac),
    .fields  (f),
    .err     (calc_err)
  );

  always_comb begin
    w1 = '0;
    w2 = '0;
    w3 = '0;
    w1[CNT_W-1:0]              = f.low;
    w1[W1_HIGH_LSB +: CNT_W]   = f.high;
    w2[W2_BYPASS]              = f.bypass;
    w2[W2_EDGE]                = f.edge_b;
    w2[W2_WFR]                 = f.wf_rise;
    w2[W2_FRAC_EN]             = f.frac_en;
    w2[W2_FRAC_LSB +: FRAC_W]  = f.frac;
    w3[W3_WFF]                 = f.wf_fall;
    w3[W3_PH_LSB +: FRAC_W]    = f.phase;
  end

  fdiv_pipe_stage #(.W(ENC_W)) u_enc_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (enc_in_valid),
    .in_ready (enc_in_ready),
    .in_data  ({calc_err, w3, w2, w1}),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_data (enc_q)
  );

  assign enc_out_word1 = enc_q[WORD_W-1:0];
  assign enc_out_word2 = enc_q[2*WORD_W-1:WORD_W];
  assign enc_out_word3 = enc_q[3*WORD_W-1:2*WORD_W];
  assign enc_out_err   = enc_q[ENC_W-1];

  fdiv_decoder #(.EW(EW)) u_dec (
    .word1  (dec_in_word1),
    .word2  (dec_in_word2),
    .eighths(dec_val)
  );

  fdiv_pipe_stage #(.W(EW)) u_dec_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (dec_in_valid),
    .in_ready (dec_in_ready),
    .in_data  (dec_val),
    .out_valid(dec_out_valid),
    .out_ready(dec_out_ready),
    .out_data (dec_out_eighths)
  );
endmodule

// File: rtl/fdiv_cfg_codec_chk.sv
module fdiv_cfg_codec_chk #(
  parameter int EW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enc_in_valid,
  input logic          enc_in_ready,
  input logic          enc_out_valid,
  input logic          enc_out_ready,
  input logic [15:0]   enc_out_word1,
  input logic [15:0]   enc_out_word2,
  input logic [15:0]   enc_out_word3,
  input logic          enc_out_err,
  input logic          dec_in_valid,
  input logic          dec_in_ready,
  input logic          dec_out_valid,
  input logic          dec_out_ready,
  input logic [EW-1:0] dec_out_eighths
);
  assert_enc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_word1)
      && $stable(enc_out_word2) && $stable(enc_out_word3) && $stable(enc_out_err));

  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_eighths));

  assert_enc_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |-> !enc_in_ready);

  assert_enc_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready |=> enc_out_valid);

  assert_dec_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_in_ready |=> dec_out_valid);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && enc_out_err |->
      enc_out_word1 == 16'h0 && enc_out_word2 == 16'h0 && enc_out_word3 == 16'h0);

  assert_bypass_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && enc_out_word2[6] |->
      enc_out_word2 == 16'h0040 && enc_out_word1 == 16'h0 && enc_out_word3 == 16'h0);

  assert_frac_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && enc_out_word2[11] |-> enc_out_word2[14:12] != 3'd0);
endmodule

bind fdiv_cfg_codec fdiv_cfg_codec_chk #(.EW(EW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enc_in_valid   (enc_in_valid),
  .enc_in_ready   (enc_in_ready),
  .enc_out_valid  (enc_out_valid),
  .enc_out_ready  (enc_out_ready),
  .enc_out_word1  (enc_out_word1),
  .enc_out_word2  (enc_out_word2),
  .enc_out_word3  (enc_out_word3),
  .enc_out_err    (enc_out_err),
  .dec_in_valid   (dec_in_valid),
  .dec_in_ready   (dec_in_ready),
  .dec_out_valid  (dec_out_valid),
  .dec_out_ready  (dec_out_ready),
  .dec_out_eighths(dec_out_eighths)
);

// File: tb/tb_fdiv_cfg_codec.sv
module tb_fdiv_cfg_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [6:0]  enc_in_int = '0;
  logic [2:0]  enc_in_frac = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b1;
  logic [15:0] enc_out_word1, enc_out_word2, enc_out_word3;
  logic        enc_out_err;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [15:0] dec_in_word1 = '0, dec_in_word2 = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b1;
  logic [10:0] dec_out_eighths;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fdiv_cfg_codec dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic encode(input int d, input int fr);
    @(negedge clk);
    enc_in_int = 7'(d); enc_in_frac = 3'(fr); enc_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    enc_in_valid = 1'b0;
  endtask

  task automatic decode(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    dec_in_word1 = a; dec_in_word2 = b; dec_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dec_in_valid = 1'b0;
  endtask

  task automatic expect_words(input int d, input int fr, input logic [15:0] e1,
                              input logic [15:0] e2, input logic [15:0] e3, input string req);
    encode(d, fr);
    chk(enc_out_valid, {req, " valid"}, enc_out_valid, 1);
    chk(enc_out_word1 == e1, {req, " word1"}, enc_out_word1, e1);
    chk(enc_out_word2 == e2, {req, " word2"}, enc_out_word2, e2);
    chk(enc_out_word3 == e3, {req, " word3"}, enc_out_word3, e3);
    chk(!enc_out_err, {req, " err"}, enc_out_err, 0);
  endtask

  task automatic t_reset;
    chk(!enc_out_valid && !dec_out_valid, "R11 out valids", {enc_out_valid, dec_out_valid}, 0);
    chk(enc_in_ready && dec_in_ready, "R11 in readies", {enc_in_ready, dec_in_ready}, 3);
  endtask

  task automatic t_bypass;
    expect_words(1, 0, 16'h0, 16'h0040, 16'h0, "R1 d=1");
    expect_words(1, 5, 16'h0, 16'h0040, 16'h0, "R1 d=1 frac ignored");
  endtask

  task automatic t_integer;
    expect_words(5, 0, 16'h0083, 16'h0080, 16'h0, "R2 d=5");
    expect_words(2, 0, 16'h0041, 16'h0000, 16'h0, "R2 d=2");
    expect_words(126, 0, 16'h0FFF, 16'h0000, 16'h0, "R2 d=126");
  endtask

  task automatic t_fractional;
    expect_words(4, 3, 16'h0041, 16'h3C00, 16'h0C00, "R3 R4 d=4 f=3");
    expect_words(3, 1, 16'h0040, 16'h1880, 16'h2400, "R3 R4 d=3 f=1");
    expect_words(2, 1, 16'h0000, 16'h1C00, 16'h0400, "R3 R4 d=2 f=1");
    expect_words(127, 7, 16'h0FFF, 16'h7880, 16'h3800, "R3 R4 d=127 f=7");
  endtask

  task automatic t_errors;
    encode(0, 3);
    chk(enc_out_err, "R7 d=0 err", enc_out_err, 1);
    chk({enc_out_word1, enc_out_word2, enc_out_word3} == '0, "R7 d=0 words",
        {enc_out_word1, enc_out_word2, enc_out_word3}, 0);
    encode(127, 0);
    chk(enc_out_err, "R7 d=127 f=0 err", enc_out_err, 1);
    chk({enc_out_word1, enc_out_word2, enc_out_word3} == '0, "R7 d=127 words",
        {enc_out_word1, enc_out_word2, enc_out_word3}, 0);
  endtask

  task automatic t_decoder;
    decode(16'hFFFF, 16'h0040);
    chk(dec_out_valid && dec_out_eighths == 11'd8, "R5 bypass", dec_out_eighths, 8);
    decode(16'h0083, 16'h0080);
    chk(dec_out_eighths == 11'd40, "R6 integer", dec_out_eighths, 40);
    decode(16'h0040, 16'h1880);
    chk(dec_out_eighths == 11'd25, "R6 edge with f=1 adds 16", dec_out_eighths, 25);
    decode(16'h0041, 16'h2880);
    chk(dec_out_eighths == 11'd26, "R6 edge with f=2 adds 8", dec_out_eighths, 26);
    decode(16'h0000, 16'h3800);
    chk(dec_out_eighths == 11'd19, "R6 no edge adds 16", dec_out_eighths, 19);
  endtask

  task automatic t_roundtrip;
    int bad = 0;
    for (int d = 0; d < 128; d++) begin
      for (int fr = 0; fr < 8; fr++) begin
        encode(d, fr);
        if (enc_out_err) begin
          if (!(d == 0 || (d == 127 && fr == 0))) begin
            bad++;
            chk(0, "R7 R8 unexpected err", d * 8 + fr, 0);
          end
        end else begin
          decode(enc_out_word1, enc_out_word2);
          if (d == 1) begin
            if (dec_out_eighths != 11'd8) begin
              bad++;
              chk(0, "R8 d=1 roundtrip", dec_out_eighths, 8);
            end
          end else if (d == 0 || (d == 127 && fr == 0)) begin
            bad++;
            chk(0, "R7 missing err", d * 8 + fr, 1);
          end else if (int'(dec_out_eighths) != d * 8 + fr) begin
            bad++;
            chk(0, "R8 roundtrip", dec_out_eighths, d * 8 + fr);
          end
        end
      end
    end
    chk(bad == 0, "R8 full sweep", bad, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    enc_out_ready = 1'b0;
    enc_in_int = 7'd5; enc_in_frac = 3'd0; enc_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    enc_in_int = 7'd4; enc_in_frac = 3'd3;
    chk(!enc_in_ready, "R9 ready low when stalled", enc_in_ready, 0);
    repeat (3) @(negedge clk);
    chk(enc_out_valid && enc_out_word1 == 16'h0083, "R9 held word1", enc_out_word1, 16'h0083);
    enc_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk(enc_out_valid && enc_out_word2 == 16'h3C00, "R10 next beat", enc_out_word2, 16'h3C00);
    @(negedge clk);
    chk(!enc_out_valid, "R10 drained", enc_out_valid, 0);
    dec_out_ready = 1'b0;
    decode(16'h0083, 16'h0080);
    repeat (2) @(negedge clk);
    chk(dec_out_valid && dec_out_eighths == 11'd40 && !dec_in_ready, "R9 decoder hold",
        dec_out_eighths, 40);
    dec_out_ready = 1'b1;
    @(negedge clk);
    chk(!dec_out_valid, "R9 decoder released", dec_out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_integer();
    t_fractional();
    t_errors();
    t_decoder();
    t_backpressure();
    t_roundtrip();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule